// File: doc/BRIEF.md
# Pointer-Indirect Load Address Unit

This block carries out one kind of data-move instruction. It loads a destination register from data memory, addressing the memory through one of four 16-bit pointer registers. When the read is done it adjusts that pointer in one of four ways: no change, plus one, minus one, or plus a signed step held in a separate step register. A second form, selected by a flag that comes with the instruction, serves as a stack pop. It first moves the pointer down by one and then reads from the new address. While a pop is in flight the block raises an interrupt hold-off, so that the decrement and the read cannot be split.

Every load takes two clock cycles. In the first cycle the block drives the read address and strobe and works out the new pointer. In the second cycle it passes the returned word to an indexed destination write port, pulses `done` and commits the new pointer. The block holds the pointers and the step register. They can be loaded through a small configuration port, and their present values are brought out for observation. A destination code for the status word also drives a guard-field write.

Top module: `ptr_load_unit`

## Requirements
- R1: An instruction is legal when bits 15:10 equal 011110. For a legal instruction, bits 9:4 appear on `dst_idx` and bits 3:0 form the operand field Y.
- R2: Y[3:2] selects the pointer used: 0 selects pointer 0, 1 selects pointer 1, 2 selects pointer 2 and 3 selects pointer 3.
- R3: `mem_rd` is high for exactly the one cycle after a legal start is accepted. In a non-pop load, `mem_addr` in that cycle is the pointer value before modification.
- R4: Y[1:0] gives the pointer update: 00 keeps it, 01 adds 1, 10 subtracts 1, 11 adds the step register as a two's-complement value. All pointer arithmetic wraps modulo 2^16.
- R5: In the second cycle `dst_we` and `done` are high and `dst_data` equals `mem_rdata`. The updated pointer is visible on `ptr_flat` (pointer k at bits 16k+15:16k) from the following cycle.
- R6: With `pop_form` high at start, the read address is the pointer minus 1 and the pointer ends at that address, whatever Y[1:0] holds.
- R7: `irq_hold` is high in both cycles of a pop and low in every cycle of a non-pop load and when idle.
- R8: When `dst_idx` equals PSW_CODE (default 42), `guard_we` pulses with `dst_we`. It carries `dst_data[11:8]` on `guard_a0` and `dst_data[15:12]` on `guard_a1`. For any other destination `guard_we` stays low.
- R9: A start while idle with a wrong opcode pulses `illegal` in the next cycle. It issues no read, raises no `busy` and changes no pointer.
- R10: A start while `busy` is high is ignored and produces no second load.
- R11: `cfg_sel` values 0..3 write a pointer and 4 writes the step register, at the clock edge where `cfg_we` is high. Such a write is ignored while `busy` is high. A write in the same cycle as a start is seen by that load.
- R12: After reset all pointers and the step register are zero, and `busy`, `done`, `mem_rd`, `dst_we`, `irq_hold` and `illegal` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to execute `instr` |
| instr | input | 16 | Instruction word |
| pop_form | input | 1 | Execute as predecrementing stack pop |
| cfg_we | input | 1 | Configuration write enable |
| cfg_sel | input | 3 | 0..3 pointer, 4 step register |
| cfg_data | input | 16 | Configuration write data |
| mem_addr | output | 16 | Data memory read address |
| mem_rd | output | 1 | Data memory read strobe |
| mem_rdata | input | 16 | Read data, valid the cycle after the strobe |
| dst_we | output | 1 | Destination register write enable |
| dst_idx | output | 6 | Destination register code |
| dst_data | output | 16 | Destination write data |
| guard_we | output | 1 | Accumulator guard-field write enable |
| guard_a0 | output | 4 | Guard field for accumulator 0 |
| guard_a1 | output | 4 | Guard field for accumulator 1 |
| busy | output | 1 | Load in progress |
| done | output | 1 | Load completes this cycle |
| illegal | output | 1 | Rejected opcode pulse |
| irq_hold | output | 1 | Interrupt hold-off during a pop |
| ptr_flat | output | 64 | All four pointers, concatenated |

## Verification
Two functions can land on the same clock edge: a configuration write and the acceptance of a load start. The bench provokes this by driving `cfg_we` to the selected pointer in the same cycle as `start`, and judges the result by the read address and the final pointer, which must both follow from the newly written value. The opposite overlap is also driven: a configuration write and a second start both arrive during the busy cycle. Both must leave no trace, which the bench checks on `ptr_flat` and through the absence of an extra destination write.

// File: rtl/ptr_load_pkg.sv
package ptr_load_pkg;
  localparam int WORD_W = 16;
  localparam int OPC_W  = 6;
  localparam logic [OPC_W-1:0] LOAD_OPC = 6'b011110;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [1:0] {
    PM_KEEP = 2'b00,
    PM_INC  = 2'b01,
    PM_DEC  = 2'b10,
    PM_STEP = 2'b11
  } pmod_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_ADDR = 2'b01,
    ST_DATA = 2'b10
  } lstate_e;

  // post-access pointer update, modulo 2^16
  function automatic word_t post_mod(word_t p, pmod_e m, word_t step);
    case (m)
      PM_INC:  post_mod = p + word_t'(1);
      PM_DEC:  post_mod = p - word_t'(1);
      PM_STEP: post_mod = p + step;
      default: post_mod = p;
    endcase
  endfunction

  // stack pop predecrement
  function automatic word_t pre_dec(word_t p);
    pre_dec = p - word_t'(1);
  endfunction
endpackage

// File: rtl/ptr_bank.sv
module ptr_bank
  import ptr_load_pkg::*;
#(
  parameter int NPTR = 4,
  localparam int SELW = $clog2(NPTR),
  localparam int CSW  = SELW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [CSW-1:0]         cfg_sel,
  input  word_t                  cfg_data,
  input  logic                   cfg_block,
  input  logic [SELW-1:0]        rd_sel,
  output word_t                  rd_ptr,
  output word_t                  step,
  input  logic                   commit,
  input  logic [SELW-1:0]        commit_sel,
  input  word_t                  commit_val,
  output logic [NPTR*WORD_W-1:0] ptr_flat
);
  word_t ptr_q [NPTR];
  word_t step_q;
  logic  cfg_ok;

  assign cfg_ok = cfg_we && !cfg_block;

  for (genvar i = 0; i < NPTR; i++) begin : g_ptr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        ptr_q[i] <= '0;
      else if (commit && commit_sel == SELW'(i))
        ptr_q[i] <= commit_val;
      else if (cfg_ok && cfg_sel == CSW'(i))
        ptr_q[i] <= cfg_data;
    end
    assign ptr_flat[i*WORD_W +: WORD_W] = ptr_q[i];

    // a pointer only moves by a commit or an accepted configuration write
    assert_ptr_moves_by_commit_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (ptr_q[i] != $past(ptr_q[i])) && !$past(cfg_ok) |-> $past(commit && commit_sel == SELW'(i)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      step_q <= '0;
    else if (cfg_ok && cfg_sel == CSW'(NPTR))
      step_q <= cfg_data;
  end

  assign rd_ptr = ptr_q[rd_sel];
  assign step   = step_q;

  // configuration is locked while a load is running
  assert_cfg_locked_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cfg_block) && !$past(commit) |-> $stable(step_q));
endmodule

// File: rtl/ptr_load_ctrl.sv
module ptr_load_ctrl
  import ptr_load_pkg::*;
#(
  parameter int NPTR = 4,
  parameter int DST_W = 6,
  localparam int SELW = $clog2(NPTR)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_go,
  input  logic             start_bad,
  input  logic             pop_in,
  input  logic [SELW-1:0]  sel_in,
  input  pmod_e            mode_in,
  input  logic [DST_W-1:0] dst_in,
  input  word_t            rd_ptr,
  input  word_t            step,
  output logic [SELW-1:0]  sel,
  output word_t            mem_addr,
  output logic             mem_rd,
  output logic             dst_we,
  output logic [DST_W-1:0] dst_idx,
  output logic             done,
  output logic             busy,
  output logic             illegal,
  output logic             irq_hold,
  output logic             commit,
  output word_t            commit_val
);
  lstate_e          st_q;
  logic [SELW-1:0]  sel_q;
  pmod_e            mode_q;
  logic [DST_W-1:0] dst_q;
  logic             pop_q;
  logic             illegal_q;
  word_t            newp_q;
  logic             in_addr, in_data;
  word_t            acc_addr;

  assign in_addr  = (st_q == ST_ADDR);
  assign in_data  = (st_q == ST_DATA);
  assign acc_addr = pop_q ? pre_dec(rd_ptr) : rd_ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      sel_q     <= '0;
      mode_q    <= PM_KEEP;
      dst_q     <= '0;
      pop_q     <= 1'b0;
      illegal_q <= 1'b0;
      newp_q    <= '0;
    end else begin
      illegal_q <= start_bad && (st_q == ST_IDLE);
      case (st_q)
        ST_IDLE: if (start_go) begin
          sel_q  <= sel_in;
          mode_q <= mode_in;
          dst_q  <= dst_in;
          pop_q  <= pop_in;
          st_q   <= ST_ADDR;
        end
        ST_ADDR: begin
          newp_q <= pop_q ? pre_dec(rd_ptr) : post_mod(rd_ptr, mode_q, step);
          st_q   <= ST_DATA;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign sel        = sel_q;
  assign mem_rd     = in_addr;
  assign mem_addr   = in_addr ? acc_addr : '0;
  assign dst_we     = in_data;
  assign dst_idx    = dst_q;
  assign done       = in_data;
  assign commit     = in_data;
  assign commit_val = newp_q;
  assign busy       = (st_q != ST_IDLE);
  assign irq_hold   = pop_q && (st_q != ST_IDLE);
  assign illegal    = illegal_q;

  assert_write_follows_read_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> dst_we && done);
  assert_single_read_R3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !mem_rd);
  assert_pop_hold_spans_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && irq_hold |=> irq_hold && dst_we);
  assert_illegal_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !mem_rd && !dst_we && !busy);
  assert_busy_no_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !mem_rd);
endmodule

// File: rtl/ptr_load_unit.sv
module ptr_load_unit
  import ptr_load_pkg::*;
#(
  parameter int NPTR    = 4,
  parameter int DST_W   = 6,
  parameter logic [5:0] PSW_CODE = 6'd42,
  parameter int GUARD_W = 4,
  parameter int A0_LSB  = 8,
  parameter int A1_LSB  = 12,
  localparam int SELW = $clog2(NPTR),
  localparam int CSW  = SELW + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic [15:0]            instr,
  input  logic                   pop_form,
  input  logic                   cfg_we,
  input  logic [CSW-1:0]         cfg_sel,
  input  logic [15:0]            cfg_data,
  output logic [15:0]            mem_addr,
  output logic                   mem_rd,
  input  logic [15:0]            mem_rdata,
  output logic                   dst_we,
  output logic [DST_W-1:0]       dst_idx,
  output logic [15:0]            dst_data,
  output logic                   guard_we,
  output logic [GUARD_W-1:0]     guard_a0,
  output logic [GUARD_W-1:0]     guard_a1,
  output logic                   busy,
  output logic                   done,
  output logic                   illegal,
  output logic                   irq_hold,
  output logic [NPTR*WORD_W-1:0] ptr_flat
);
  logic            opc_ok, start_go, start_bad;
  logic [SELW-1:0] sel;
  word_t           rd_ptr, step, commit_val;
  logic            commit;

  assign opc_ok    = (instr[15:10] == LOAD_OPC);
  assign start_go  = start && opc_ok && !busy;
  assign start_bad = start && !opc_ok && !busy;

  ptr_bank #(.NPTR(NPTR)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data), .cfg_block(busy),
    .rd_sel(sel), .rd_ptr(rd_ptr), .step(step),
    .commit(commit), .commit_sel(sel), .commit_val(commit_val),
    .ptr_flat(ptr_flat)
  );

  ptr_load_ctrl #(.NPTR(NPTR), .DST_W(DST_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .start_go(start_go), .start_bad(start_bad), .pop_in(pop_form),
    .sel_in(instr[3 -: SELW]), .mode_in(pmod_e'(instr[1:0])), .dst_in(instr[9:4]),
    .rd_ptr(rd_ptr), .step(step), .sel(sel),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .dst_we(dst_we), .dst_idx(dst_idx),
    .done(done), .busy(busy), .illegal(illegal), .irq_hold(irq_hold),
    .commit(commit), .commit_val(commit_val)
  );

  assign dst_data = mem_rdata;
  assign guard_we = dst_we && (dst_idx == PSW_CODE);
  assign guard_a0 = dst_data[A0_LSB +: GUARD_W];
  assign guard_a1 = dst_data[A1_LSB +: GUARD_W];

  assert_guard_with_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    guard_we |-> dst_we && done);
  assert_illegal_after_bad_R9: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> $past(start && !opc_ok));
endmodule

// File: tb/test_ptr_load_unit.sv
module test_ptr_load_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] instr = '0;
  logic        pop_form = 1'b0;
  logic        cfg_we = 1'b0;
  logic [2:0]  cfg_sel = '0;
  logic [15:0] cfg_data = '0;
  logic [15:0] mem_addr, dst_data, mem_rdata;
  logic        mem_rd, dst_we, guard_we, busy, done, illegal, irq_hold;
  logic [5:0]  dst_idx;
  logic [3:0]  guard_a0, guard_a1;
  logic [63:0] ptr_flat;

  int nchk = 0;
  int nerr = 0;

  typedef struct {
    logic [5:0]  idx;
    logic [15:0] data;
    int          sel;
    logic [15:0] ptr;
    string       req;
  } exp_t;
  exp_t sb[$];
  logic [15:0] model_ptr [4];
  logic [15:0] model_j;

  always #2.5 clk = ~clk;

  ptr_load_unit i_ptr_load_unit (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .pop_form(pop_form),
    .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_rdata(mem_rdata),
    .dst_we(dst_we), .dst_idx(dst_idx), .dst_data(dst_data),
    .guard_we(guard_we), .guard_a0(guard_a0), .guard_a1(guard_a1),
    .busy(busy), .done(done), .illegal(illegal), .irq_hold(irq_hold),
    .ptr_flat(ptr_flat)
  );

  function automatic logic [15:0] mem_val(logic [15:0] a);
    return {a[7:0], a[15:8]} ^ 16'h3C96;
  endfunction

  always_ff @(posedge clk)
    if (mem_rd) mem_rdata <= mem_val(mem_addr);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bench's own statement of the pointer update
  function automatic logic [15:0] exp_next(logic [15:0] p, int mode, logic [15:0] j, bit pop);
    if (pop) return 16'(p + 16'hFFFF);
    if (mode == 1) return 16'(p + 1);
    if (mode == 2) return 16'(p + 16'hFFFF);
    if (mode == 3) return 16'(p + j);
    return p;
  endfunction

  // monitor: compares destination writes and the pointer that follows
  bit pend = 1'b0;
  exp_t cur;
  always @(negedge clk) begin
    if (pend) begin
      check({cur.req, " final pointer"}, {16'h0, ptr_flat[cur.sel*16 +: 16]}, {16'h0, cur.ptr});
      pend = 1'b0;
    end
    if (dst_we) begin
      if (sb.size() == 0) begin
        check("R10 unexpected destination write", 1, 0);
      end else begin
        cur = sb.pop_front();
        check("R1 dst_idx", {26'h0, dst_idx}, {26'h0, cur.idx});
        check("R5 dst_data", {16'h0, dst_data}, {16'h0, cur.data});
        check("R5 done", {31'h0, done}, 1);
        check("R8 guard_we", {31'h0, guard_we}, {31'h0, cur.idx == 6'd42});
        if (cur.idx == 6'd42)
          check("R8 guard fields", {24'h0, guard_a1, guard_a0}, {24'h0, cur.data[15:8]});
        pend = 1'b1;
      end
    end
  end

  task automatic cfg_wr(int s, logic [15:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 3'(s); cfg_data = v;
    @(negedge clk);
    cfg_we = 1'b0;
    if (s < 4) model_ptr[s] = v; else model_j = v;
  endtask

  // driver: push the expectation, start, check the address cycle
  task automatic run_load(int s, int mode, bit pop, logic [5:0] dst, string req,
                          bit same_cycle_cfg = 0, logic [15:0] cfg_v = 0);
    exp_t e;
    logic [15:0] p, a;
    @(negedge clk);
    if (same_cycle_cfg) begin
      cfg_we = 1'b1; cfg_sel = 3'(s); cfg_data = cfg_v; model_ptr[s] = cfg_v;
    end
    p = model_ptr[s];
    a = pop ? 16'(p + 16'hFFFF) : p;
    e.idx = dst; e.data = mem_val(a); e.sel = s;
    e.ptr = exp_next(p, mode, model_j, pop); e.req = req;
    model_ptr[s] = e.ptr;
    sb.push_back(e);
    instr = {6'b011110, dst, 2'(s), 2'(mode)};
    pop_form = pop; start = 1'b1;
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    check({req, " R3 mem_rd"}, {31'h0, mem_rd}, 1);
    check({req, " R3 mem_addr"}, {16'h0, mem_addr}, {16'h0, a});
    check({req, " R7 irq_hold"}, {31'h0, irq_hold}, {31'h0, pop});
    @(negedge clk);
    check({req, " R7 irq_hold data cycle"}, {31'h0, irq_hold}, {31'h0, pop});
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    for (int k = 0; k < 4; k++) model_ptr[k] = '0;
    model_j = '0;
    repeat (3) @(negedge clk);
    check("R12 reset pointers", ptr_flat[31:0], 0);
    check("R12 reset pointers hi", ptr_flat[63:32], 0);
    check("R12 reset outputs", {26'h0, busy, done, mem_rd, dst_we, irq_hold, illegal}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 idle after reset", {29'h0, busy, done, illegal}, 0);

    // every pointer with every update mode (R2, R4)
    cfg_wr(4, 16'h0010);
    for (int s = 0; s < 4; s++)
      for (int m = 0; m < 4; m++) begin
        cfg_wr(s, 16'(16'h1000 * s + 16'h0123 * m + 5));
        run_load(s, m, 0, 6'(s * 4 + m + 1), (m == 3) ? "R4 step mode" : "R2 R4 select/mode");
      end

    // wraparound corners (R4)
    cfg_wr(1, 16'hFFFF); run_load(1, 1, 0, 6'd3, "R4 wrap up");
    cfg_wr(2, 16'h0000); run_load(2, 2, 0, 6'd4, "R4 wrap down");
    cfg_wr(4, 16'hFFFD); cfg_wr(3, 16'h0002); run_load(3, 3, 0, 6'd5, "R4 negative step");
    cfg_wr(4, 16'h0020); cfg_wr(0, 16'hFFF0); run_load(0, 3, 0, 6'd6, "R4 step wrap");

    // pop form (R6, R7)
    cfg_wr(2, 16'h0000); run_load(2, 0, 1, 6'd7, "R6 pop wrap");
    cfg_wr(1, 16'h0100); run_load(1, 1, 1, 6'd8, "R6 pop ignores mode");

    // status word destination (R8)
    cfg_wr(0, 16'h4321); run_load(0, 1, 0, 6'd42, "R8 status dest");

    // configuration write in the start cycle (R11)
    run_load(3, 1, 0, 6'd9, "R11 same-cycle cfg", 1, 16'hABCD);

    // illegal opcode (R9)
    @(negedge clk);
    instr = 16'h7C13; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R9 illegal pulse", {31'h0, illegal}, 1);
    check("R9 no read/busy", {30'h0, mem_rd, busy}, 0);
    @(negedge clk);
    check("R9 illegal clears", {31'h0, illegal}, 0);
    check("R9 pointer 1 unchanged", {16'h0, ptr_flat[31:16]}, {16'h0, model_ptr[1]});

    // second start and cfg write while busy (R10, R11)
    cfg_wr(0, 16'h0200);
    cfg_wr(2, 16'h0300);
    begin
      exp_t e;
      e.idx = 6'd11; e.data = mem_val(16'h0200); e.sel = 0;
      e.ptr = 16'h0201; e.req = "R10 first load";
      sb.push_back(e);
      model_ptr[0] = 16'h0201;
    end
    @(negedge clk);
    instr = {6'b011110, 6'd11, 2'd0, 2'd1}; pop_form = 1'b0; start = 1'b1;
    @(negedge clk);
    instr = {6'b011110, 6'd12, 2'd2, 2'd1};
    cfg_we = 1'b1; cfg_sel = 3'd2; cfg_data = 16'h7777;
    @(negedge clk);
    start = 1'b0; cfg_we = 1'b0;
    repeat (4) @(negedge clk);
    check("R10 no second load", sb.size(), 0);
    check("R11 busy cfg ignored", {16'h0, ptr_flat[47:32]}, {16'h0, 16'h0300});
    check("R10 idle", {31'h0, busy}, 0);

    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule